// File: doc/BRIEF.md
# Ethernet Receive Frame Qualifier

This block receives 4-bit MII receive nibbles and turns them into a byte-wide frame stream. Nibbles are paired into bytes, low nibble first. The preamble is checked against a selectable length limit, and its content can also be checked strictly. The start delimiter is removed, and every byte after it, including the four check bytes, is passed on with valid, start and end markers. The first 14 bytes are held in a short delay line until the type field has arrived. The block can then decide whether the frame may leave at all before any byte of it appears on the output.

The block recognises MAC control frames by their type value. It drops them or forwards them according to a configuration input. When receive flow control is enabled, a pause request with its timer value is reported to the transmit side. For frames that carry a length instead of a type, the length can be compared with the measured payload size. A loopback input replaces the receive pins with the local transmit pins. A soft reset returns all internal state to idle and leaves the configuration inputs alone.

Top module: `eth_rx_qualifier`

## Requirements
- R1: Nibbles are assembled low nibble first. Preamble nibbles are 0x5 and the start delimiter byte is 0xD5. Every byte after the delimiter appears on `out_data` in arrival order, with `out_sof` on the first byte and `out_eof` on the last. After reset, `out_valid` and `pause_req` are 0.
- R2: With `cfg_short_pre`=1, up to 11 preamble bytes before the delimiter are accepted. A 12th non-delimiter byte causes the frame to be discarded, and no byte of it is output.
- R3: With `cfg_short_pre`=0, up to 32 preamble bytes are accepted. A 33rd non-delimiter byte causes the frame to be discarded.
- R4: With `cfg_strict_pre`=1, any preamble byte other than 0x55 discards the frame. With it at 0, preamble content is ignored and only 0xD5 is sought.
- R5: A frame whose big-endian type field (bytes 12 and 13 after the delimiter) equals 0x8808 is a control frame. It is never output when `cfg_pass_ctrl`=0 and is output unchanged when `cfg_pass_ctrl`=1.
- R6: If a control frame carries opcode 0x0001 (bytes 14 and 15) and `cfg_rx_flow`=1, `pause_req` pulses for exactly one cycle, with `pause_quanta` set to bytes 16 and 17 taken big-endian. With `cfg_rx_flow`=0 no pulse occurs, and the frame follows R5.
- R7: With `cfg_len_chk`=1 and a type/length field of at most 1500, `out_len_err` is set with `out_eof` when the field differs from the payload count. The payload count is the number of bytes after the delimiter minus 18. The one exception is a payload of exactly 46 bytes with a field below 46, which counts as padding and is accepted. A field of 0x0600 or more, or `cfg_len_chk`=0, never sets the flag.
- R8: A receive error after output has begun stops further data bytes and ends the frame with `out_eof` and `out_drop` both set. A frame that ends or errs before its 14th byte produces no output.
- R9: With `cfg_loopback`=1, `mii_txd`, `mii_tx_en` and `mii_tx_er` replace the receive pins. With it at 0, the transmit pins have no effect.
- R10: A `soft_rst` pulse abandons any frame in progress, so none of it is output. It clears the output strobes on the next cycle. The next frame is then received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous reset, active low |
| soft_rst | input | 1 | Synchronous soft reset of internal state |
| cfg_short_pre | input | 1 | 1: 11-byte preamble limit, 0: 32-byte limit |
| cfg_strict_pre | input | 1 | Check preamble byte content |
| cfg_pass_ctrl | input | 1 | Forward control frames |
| cfg_rx_flow | input | 1 | Report received pause requests |
| cfg_len_chk | input | 1 | Compare length field with payload |
| cfg_loopback | input | 1 | Feed transmit pins into the receiver |
| mii_rxd | input | 4 | Receive nibble |
| mii_rx_dv | input | 1 | Receive data valid |
| mii_rx_er | input | 1 | Receive error |
| mii_txd | input | 4 | Transmit nibble (loopback source) |
| mii_tx_en | input | 1 | Transmit enable (loopback source) |
| mii_tx_er | input | 1 | Transmit error (loopback source) |
| out_data | output | 8 | Frame byte |
| out_valid | output | 1 | Byte valid |
| out_sof | output | 1 | First byte of frame |
| out_eof | output | 1 | Last byte of frame |
| out_drop | output | 1 | Frame rejected after output began (with eof) |
| out_len_err | output | 1 | Length field mismatch (with eof) |
| pause_req | output | 1 | One-cycle pause request strobe |
| pause_quanta | output | 16 | Requested pause time |

## Verification
The assertions assume that data valid stays low for at least 16 cycles between frames. The 13 buffered bytes of a frame drain out during that gap, and input seen while they drain is ignored. They also assume that each frame starts on a byte boundary, so preamble nibbles pair up. The bench drives every frame as whole bytes with a 30-cycle idle gap and holds the configuration inputs steady during each frame. Soft reset is the only event it applies in mid-frame.

// File: rtl/eth_rx_qualifier.sv
module eth_rx_qualifier #(
  parameter int HDR_BYTES = 14,
  parameter int SHORT_PRE = 11,
  parameter int LONG_PRE  = 32,
  parameter int MAX_LEN   = 1500,
  parameter int MIN_PAY   = 46,
  parameter int CNT_W     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        cfg_short_pre,
  input  logic        cfg_strict_pre,
  input  logic        cfg_pass_ctrl,
  input  logic        cfg_rx_flow,
  input  logic        cfg_len_chk,
  input  logic        cfg_loopback,
  input  logic [3:0]  mii_rxd,
  input  logic        mii_rx_dv,
  input  logic        mii_rx_er,
  input  logic [3:0]  mii_txd,
  input  logic        mii_tx_en,
  input  logic        mii_tx_er,
  output logic [7:0]  out_data,
  output logic        out_valid,
  output logic        out_sof,
  output logic        out_eof,
  output logic        out_drop,
  output logic        out_len_err,
  output logic        pause_req,
  output logic [15:0] pause_quanta
);
  localparam int DLY     = HDR_BYTES - 1;
  localparam int PRE_W   = $clog2(LONG_PRE + 1);
  localparam int DCW     = $clog2(DLY + 1);
  localparam int IX_TYPE = HDR_BYTES - 1;
  localparam int IX_OP   = HDR_BYTES + 1;
  localparam int IX_QNT  = HDR_BYTES + 3;
  localparam int OVH     = HDR_BYTES + 4;

  typedef enum logic [2:0] {S_PRE, S_HDR, S_BODY, S_SKIP, S_DRAIN} st_t;

  wire [3:0] in_d  = cfg_loopback ? mii_txd   : mii_rxd;
  wire       in_dv = cfg_loopback ? mii_tx_en : mii_rx_dv;
  wire       in_er = cfg_loopback ? mii_tx_er : mii_rx_er;

  st_t             st;
  logic [3:0]      r_d, lo;
  logic            r_dv, r_er, ph;
  logic [PRE_W-1:0] pre_cnt;
  logic [CNT_W-1:0] idx;
  logic [DCW-1:0]  dcnt;
  logic [7:0]      dly [DLY];
  logic            fwd, ctrl, op_ok, bad, lerr;
  logic [15:0]     len_fld;

  wire             stb     = r_dv & ph;
  wire [7:0]       b       = {r_d, lo};
  wire [15:0]      pair    = {dly[0], b};
  wire [PRE_W-1:0] pre_lim = cfg_short_pre ? PRE_W'(SHORT_PRE) : PRE_W'(LONG_PRE);
  wire [CNT_W-1:0] pay     = (idx >= CNT_W'(OVH)) ? idx - CNT_W'(OVH) : '0;
  wire             len_bad = cfg_len_chk && (len_fld <= 16'(MAX_LEN)) &&
                             (32'(len_fld) != 32'(pay)) &&
                             !(pay == CNT_W'(MIN_PAY) && len_fld < 16'(MIN_PAY));
  wire             is_ctl  = (pair == 16'h8808);
  wire             take    = r_dv && !r_er && stb;
  wire             shift_en = (st == S_HDR && take) || (st == S_BODY && take && !bad) ||
                              (st == S_DRAIN);

  always_ff @(posedge clk)
    if (shift_en) begin
      for (int i = DLY - 1; i > 0; i--) dly[i] <= dly[i-1];
      dly[0] <= (st == S_DRAIN) ? 8'h00 : b;
    end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      st <= S_PRE; r_d <= '0; lo <= '0; r_dv <= 1'b0; r_er <= 1'b0; ph <= 1'b0;
      pre_cnt <= '0; idx <= '0; dcnt <= '0; fwd <= 1'b0; ctrl <= 1'b0;
      op_ok <= 1'b0; bad <= 1'b0; lerr <= 1'b0; len_fld <= '0;
      out_data <= '0; out_valid <= 1'b0; out_sof <= 1'b0; out_eof <= 1'b0;
      out_drop <= 1'b0; out_len_err <= 1'b0; pause_req <= 1'b0; pause_quanta <= '0;
    end else begin
      out_valid <= 1'b0; out_sof <= 1'b0; out_eof <= 1'b0;
      out_drop <= 1'b0; out_len_err <= 1'b0; pause_req <= 1'b0;
      r_d <= in_d; r_dv <= in_dv; r_er <= in_er;
      ph <= r_dv ? ~ph : 1'b0;
      if (r_dv && !ph) lo <= r_d;
      case (st)
        S_PRE:
          if (!r_dv) pre_cnt <= '0;
          else if (r_er) st <= S_SKIP;
          else if (stb) begin
            if (b == 8'hD5) begin
              st <= S_HDR; idx <= '0; bad <= 1'b0;
            end else if ((cfg_strict_pre && b != 8'h55) || pre_cnt == pre_lim)
              st <= S_SKIP;
            else pre_cnt <= pre_cnt + 1'b1;
          end
        S_SKIP:
          if (!r_dv) begin st <= S_PRE; pre_cnt <= '0; end
        S_HDR:
          if (!r_dv) begin st <= S_PRE; pre_cnt <= '0; end
          else if (r_er) st <= S_SKIP;
          else if (stb) begin
            idx <= idx + 1'b1;
            if (idx == CNT_W'(IX_TYPE)) begin
              st <= S_BODY; len_fld <= pair; ctrl <= is_ctl; op_ok <= 1'b0;
              fwd <= !is_ctl || cfg_pass_ctrl;
              out_valid <= !is_ctl || cfg_pass_ctrl;
              out_sof <= !is_ctl || cfg_pass_ctrl;
              out_data <= dly[DLY-1];
            end
          end
        S_BODY:
          if (!r_dv) begin
            st <= S_DRAIN; dcnt <= DCW'(DLY); lerr <= len_bad;
          end else if (r_er) bad <= 1'b1;
          else if (stb && !bad) begin
            if (idx != '1) idx <= idx + 1'b1;
            out_valid <= fwd; out_data <= dly[DLY-1];
            if (idx == CNT_W'(IX_OP)) op_ok <= ctrl && pair == 16'h0001;
            if (idx == CNT_W'(IX_QNT) && op_ok && cfg_rx_flow) begin
              pause_req <= 1'b1; pause_quanta <= pair;
            end
          end
        S_DRAIN: begin
          out_valid <= fwd; out_data <= dly[DLY-1];
          dcnt <= dcnt - 1'b1;
          if (dcnt == DCW'(1)) begin
            out_eof <= fwd; out_drop <= fwd && bad;
            out_len_err <= fwd && lerr && !bad;
            st <= S_PRE; pre_cnt <= '0;
          end
        end
        default: st <= S_PRE;
      endcase
    end
  end
endmodule

// File: rtl/eth_rx_qualifier_chk.sv
module eth_rx_qualifier_chk (
  input logic clk,
  input logic rst_n,
  input logic soft_rst,
  input logic out_valid,
  input logic out_sof,
  input logic out_eof,
  input logic out_drop,
  input logic out_len_err,
  input logic pause_req
);
  p_sof_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);
  p_eof_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_valid);
  p_sof_not_eof_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_sof && out_eof));
  p_pause_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |=> !pause_req);
  p_lenerr_at_eof_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_len_err |-> out_eof);
  p_drop_at_eof_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_drop |-> (out_eof && !out_len_err));
  p_soft_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!out_valid && !pause_req));
endmodule

bind eth_rx_qualifier eth_rx_qualifier_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .out_valid(out_valid),
  .out_sof(out_sof), .out_eof(out_eof), .out_drop(out_drop),
  .out_len_err(out_len_err), .pause_req(pause_req)
);

// File: tb/tb_eth_rx_qualifier.sv
`timescale 1ns/1ps
module tb_eth_rx_qualifier;
  logic clk = 0, rst_n = 0, soft_rst = 0;
  logic cfg_short_pre = 0, cfg_strict_pre = 0, cfg_pass_ctrl = 0;
  logic cfg_rx_flow = 0, cfg_len_chk = 0, cfg_loopback = 0;
  logic [3:0] mii_rxd = 0, mii_txd = 0;
  logic mii_rx_dv = 0, mii_rx_er = 0, mii_tx_en = 0, mii_tx_er = 0;
  logic [7:0] out_data;
  logic out_valid, out_sof, out_eof, out_drop, out_len_err, pause_req;
  logic [15:0] pause_quanta;

  eth_rx_qualifier dut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] got[$];
  int sof_n, eof_n, drop_n, lerr_n, pause_n, sof_first;
  logic [15:0] q_seen;

  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin
      if (out_sof && got.size() == 0) sof_first++;
      got.push_back(out_data);
    end
    if (out_sof) sof_n++;
    if (out_eof) eof_n++;
    if (out_drop) drop_n++;
    if (out_len_err) lerr_n++;
    if (pause_req) begin pause_n++; q_seen = pause_quanta; end
  end

  task automatic clr();
    got.delete(); sof_n = 0; eof_n = 0; drop_n = 0; lerr_n = 0; pause_n = 0; sof_first = 0;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic nib(input logic [3:0] d, input logic dv, input logic er, input bit lb);
    @(negedge clk);
    if (lb) begin mii_txd = d; mii_tx_en = dv; mii_tx_er = er; mii_rx_dv = 0; mii_rx_er = 0; end
    else begin mii_rxd = d; mii_rx_dv = dv; mii_rx_er = er; mii_tx_en = 0; mii_tx_er = 0; end
  endtask

  function automatic void mk(output logic [7:0] f[$], input logic [15:0] tl,
                             input int nbody, input logic [15:0] op, input logic [15:0] q);
    f.delete();
    for (int i = 0; i < 12; i++) f.push_back(8'(8'h10 + i));
    f.push_back(tl[15:8]); f.push_back(tl[7:0]);
    for (int i = 0; i < nbody; i++)
      if (i == 0) f.push_back(op[15:8]);
      else if (i == 1) f.push_back(op[7:0]);
      else if (i == 2) f.push_back(q[15:8]);
      else if (i == 3) f.push_back(q[7:0]);
      else f.push_back(8'(i + 3));
    for (int i = 0; i < 4; i++) f.push_back(8'(8'hF0 + i));
  endfunction

  task automatic send(input int npre, input int badpos, input logic [7:0] f[$],
                      input int er_at, input int sr_at, input bit lb);
    clr();
    for (int i = 0; i < npre; i++) begin
      logic [7:0] pb;
      pb = (i == badpos) ? 8'h5A : 8'h55;
      nib(pb[3:0], 1, 0, lb); nib(pb[7:4], 1, 0, lb);
    end
    nib(4'h5, 1, 0, lb); nib(4'hD, 1, 0, lb);
    for (int i = 0; i < f.size(); i++) begin
      if (i == sr_at) soft_rst = 1;
      nib(f[i][3:0], 1, (i == er_at), lb);
      soft_rst = 0;
      nib(f[i][7:4], 1, (i == er_at), lb);
    end
    nib(0, 0, 0, lb);
    repeat (30) @(negedge clk);
  endtask

  task automatic expect_frame(input string req, input logic [7:0] f[$], input bit fwd);
    if (fwd) begin
      int mism = 0;
      chk(got.size() == f.size(), req, got.size(), f.size());
      for (int i = 0; i < f.size() && i < got.size(); i++) if (got[i] !== f[i]) mism++;
      chk(mism == 0, req, mism, 0);
      chk(sof_first == 1 && sof_n == 1 && eof_n == 1, req, sof_n * 10 + eof_n, 11);
    end else
      chk(got.size() == 0 && eof_n == 0, req, got.size(), 0);
  endtask

  logic [7:0] fr[$];

  task automatic t_reset();
    chk(out_valid == 0 && pause_req == 0, "R1 reset", out_valid, 0);
  endtask

  task automatic t_basic();
    mk(fr, 16'h0800, 30, 16'hA1B2, 16'hC3D4);
    send(7, -1, fr, -1, -1, 0);
    expect_frame("R1 basic", fr, 1);
    chk(drop_n == 0 && lerr_n == 0, "R1 flags", drop_n + lerr_n, 0);
  endtask

  task automatic t_pre_short();
    cfg_short_pre = 1;
    mk(fr, 16'h0800, 20, 0, 0);
    send(11, -1, fr, -1, -1, 0); expect_frame("R2 11 bytes", fr, 1);
    send(12, -1, fr, -1, -1, 0); expect_frame("R2 12 bytes", fr, 0);
    cfg_short_pre = 0;
  endtask

  task automatic t_pre_long();
    mk(fr, 16'h0800, 20, 0, 0);
    send(12, -1, fr, -1, -1, 0); expect_frame("R3 12 bytes", fr, 1);
    send(32, -1, fr, -1, -1, 0); expect_frame("R3 32 bytes", fr, 1);
    send(33, -1, fr, -1, -1, 0); expect_frame("R3 33 bytes", fr, 0);
  endtask

  task automatic t_strict();
    mk(fr, 16'h0800, 20, 0, 0);
    cfg_strict_pre = 1;
    send(7, 3, fr, -1, -1, 0); expect_frame("R4 strict bad", fr, 0);
    send(7, -1, fr, -1, -1, 0); expect_frame("R4 strict good", fr, 1);
    cfg_strict_pre = 0;
    send(7, 3, fr, -1, -1, 0); expect_frame("R4 lax bad", fr, 1);
  endtask

  task automatic t_ctrl();
    mk(fr, 16'h8808, 46, 16'h0002, 16'h0000);
    send(7, -1, fr, -1, -1, 0); expect_frame("R5 ctrl drop", fr, 0);
    cfg_pass_ctrl = 1;
    send(7, -1, fr, -1, -1, 0); expect_frame("R5 ctrl pass", fr, 1);
    cfg_pass_ctrl = 0;
  endtask

  task automatic t_pause();
    mk(fr, 16'h8808, 46, 16'h0001, 16'h1234);
    cfg_rx_flow = 1;
    send(7, -1, fr, -1, -1, 0);
    chk(pause_n == 1, "R6 pause count", pause_n, 1);
    chk(q_seen == 16'h1234, "R6 quanta", q_seen, 16'h1234);
    expect_frame("R6 pause frame dropped", fr, 0);
    cfg_rx_flow = 0;
    send(7, -1, fr, -1, -1, 0);
    chk(pause_n == 0, "R6 flow off", pause_n, 0);
  endtask

  task automatic t_len();
    cfg_len_chk = 1;
    mk(fr, 16'd20, 20, 0, 0); send(7, -1, fr, -1, -1, 0);
    chk(eof_n == 1 && lerr_n == 0, "R7 match", lerr_n, 0);
    mk(fr, 16'd25, 20, 0, 0); send(7, -1, fr, -1, -1, 0);
    chk(eof_n == 1 && lerr_n == 1, "R7 mismatch", lerr_n, 1);
    mk(fr, 16'd10, 46, 0, 0); send(7, -1, fr, -1, -1, 0);
    chk(lerr_n == 0, "R7 padded", lerr_n, 0);
    mk(fr, 16'h0800, 20, 0, 0); send(7, -1, fr, -1, -1, 0);
    chk(lerr_n == 0, "R7 type field", lerr_n, 0);
    cfg_len_chk = 0;
    mk(fr, 16'd25, 20, 0, 0); send(7, -1, fr, -1, -1, 0);
    chk(lerr_n == 0, "R7 disabled", lerr_n, 0);
  endtask

  task automatic t_err();
    mk(fr, 16'h0800, 30, 0, 0);
    send(7, -1, fr, 20, -1, 0);
    chk(eof_n == 1 && drop_n == 1, "R8 drop flag", drop_n, 1);
    chk(got.size() < fr.size(), "R8 truncated", got.size(), fr.size() - 1);
    fr = fr[0:9];
    send(7, -1, fr, -1, -1, 0); expect_frame("R8 short", fr, 0);
  endtask

  task automatic t_lb();
    mk(fr, 16'h0800, 20, 0, 0);
    send(7, -1, fr, -1, -1, 1); expect_frame("R9 tx pins ignored", fr, 0);
    cfg_loopback = 1;
    send(7, -1, fr, -1, -1, 1); expect_frame("R9 loopback", fr, 1);
    cfg_loopback = 0;
  endtask

  task automatic t_soft();
    mk(fr, 16'h0800, 20, 0, 0);
    send(7, -1, fr, -1, 10, 0); expect_frame("R10 abandoned", fr, 0);
    send(7, -1, fr, -1, -1, 0); expect_frame("R10 next frame", fr, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_basic(); t_pre_short(); t_pre_long(); t_strict();
    t_ctrl(); t_pause(); t_len(); t_err(); t_lb(); t_soft();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule